// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Registers

This block keeps the completion and error bookkeeping of a NAND-style flash controller. The operation engine reports the end of a load, program, erase or reset, and any failure, as single-cycle pulses. The block gathers these into sticky bits: an interrupt-status word with a master "operation done" flag, and a controller-status word that holds the error flags. Software reads both words over a simple register bus. It acknowledges by writing an AND-mask into the interrupt word. When that mask clears the master flag, all error flags are wiped with it.

The block also guards the command register. A command write is taken only after the previous operation has been acknowledged, that is, when the master flag is clear. A recognised command goes to the engine as a one-cycle strobe. An unrecognised command is turned straight into a command error with the master flag set.

Two configuration words are held here. The first one sets the active level of the interrupt pin and drives the ready pin. Both pins are registered. A cold reset (`rst_n` low) and a hot reset (`hot_rst` pulse) both restore the configuration defaults and raise the ready pin. They differ in the reset-kind bit they leave in the interrupt word.

Top module: `flash_irq_status_unit`

## Requirements
- R1: After a cold reset the interrupt word reads 0x8080, configuration 1 reads 0x40C0, configuration 2 and the controller-status word read 0x0000, the command register reads 0x0000, and `rdy_o` and `irq_o` are both 1.
- R2: A `hot_rst` pulse sets the interrupt word to 0x8010, restores configuration 1 to 0x40C0 and configuration 2 to 0x0000, clears every error flag and the command register, and drives `rdy_o` to 1 at the same clock edge.
- R3: A completion pulse sets interrupt bit 15 together with its own kind bit: load sets bit 7, program bit 6, erase bit 5, reset bit 4. The bits stay set until software clears them.
- R4: Every error pulse sets controller-status bit 10 (command error) along with its own flag: a load error sets bit 13, a program error bit 12, an erase error bit 11.
- R5: Writing the interrupt register (address 4) replaces the word with its AND with the written value. If bit 15 is 0 after that, controller-status bits 10 to 13 are cleared in the same cycle.
- R6: When an event pulse and an interrupt-register write fall in the same cycle, the mask is applied first and the event's bits are ORed in afterwards, so the event survives.
- R7: A write to the command register (address 0) while interrupt bit 15 is 1 is ignored: `cmd_valid` stays 0 and the register keeps its old value.
- R8: The recognised command codes are 0x0000, 0x0013, 0x0080, 0x001A, 0x001B, 0x0023, 0x0027, 0x002A, 0x002C, 0x0030, 0x0065, 0x0071, 0x0094, 0x0095, 0x00B0, 0x00F0 and 0x00F3. An accepted write of any other value sets controller-status bit 10 and interrupt bit 15, and raises no `cmd_valid`.
- R9: `irq_o` equals interrupt bit 15 XOR the inverse of configuration-1 bit 6, one clock after those values change. With bit 6 = 1 the pin is active-high; with bit 6 = 0 it is active-low.
- R10: `rdy_o` takes configuration-1 bit 7 one clock after configuration 1 (address 1) is written.
- R11: A read of configuration 1 returns the stored value with bits 4..0 forced to 0. Configuration 2 (address 2) reads back all 16 bits as written.
- R12: An accepted, recognised command write makes `cmd_valid` 1 for exactly the one cycle after the write edge, with `cmd_code` showing the code. The command register then reads back that code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| hot_rst | input | 1 | Synchronous hot-reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 command, 1 config 1, 2 config 2, 3 controller status, 4 interrupt status |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Combinational read data for `reg_addr` |
| evt_load | input | 1 | Load completed pulse |
| evt_prog | input | 1 | Program completed pulse |
| evt_erase | input | 1 | Erase completed pulse |
| evt_reset | input | 1 | Reset completed pulse |
| err_load | input | 1 | Load failed pulse |
| err_prog | input | 1 | Program failed pulse |
| err_erase | input | 1 | Erase failed pulse |
| cmd_valid | output | 1 | One-cycle strobe for an accepted recognised command |
| cmd_code | output | DW | Code of the most recently accepted command |
| irq_o | output | 1 | Registered interrupt pin |
| rdy_o | output | 1 | Registered ready pin |

## Verification
A register write, an event pulse or a hot reset changes the status words, the configuration words and the command register at the clock edge that samples it. Read data and `cmd_valid` are therefore due right after that edge. The pins trail by one more edge.

Each driver task applies its stimulus on a falling edge and returns on the falling edge after the sampling edge. It queues register and strobe expectations at that point. For pin expectations it first waits one more falling edge. The monitor pops these expectations and compares them while all signals are stable.

// File: rtl/fis_pkg.sv
package fis_pkg;

    // Interrupt-status bit positions
    localparam int B_DONE  = 15;
    localparam int B_LOAD  = 7;
    localparam int B_PROG  = 6;
    localparam int B_ERASE = 5;
    localparam int B_RESET = 4;

    // Controller-status error bit positions
    localparam int E_CMD   = 10;
    localparam int E_ERASE = 11;
    localparam int E_PROG  = 12;
    localparam int E_LOAD  = 13;

    // Configuration-1 bit positions
    localparam int C_POL   = 6;
    localparam int C_RDY   = 7;
    localparam int C_HIDE  = 5;   // low bits hidden on read

    localparam logic [15:0] CFG1_DEF  = 16'h40C0;
    localparam logic [15:0] CFG2_DEF  = 16'h0000;
    localparam logic [15:0] IST_COLD  = 16'h8080;
    localparam logic [15:0] IST_HOT   = 16'h8010;
    localparam logic [15:0] ERR_BITS  = 16'h3C00;

    typedef enum logic [2:0] {
        RA_CMD   = 3'd0,
        RA_CFG1  = 3'd1,
        RA_CFG2  = 3'd2,
        RA_CSTAT = 3'd3,
        RA_ISTAT = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic load;
        logic prog;
        logic erase;
        logic reset;
    } done_evt_t;

    typedef struct packed {
        logic load;
        logic prog;
        logic erase;
    } fail_evt_t;

    function automatic logic code_known(input logic [15:0] c);
        case (c)
            16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
            16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0030,
            16'h0065, 16'h0071, 16'h0094, 16'h0095, 16'h00B0,
            16'h00F0, 16'h00F3: return 1'b1;
            default:            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fis_status_core.sv
module fis_status_core
    import fis_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hot_rst,
    input  logic          ack_wr,
    input  logic [DW-1:0] ack_mask,
    input  done_evt_t     done_evt,
    input  fail_evt_t     fail_evt,
    input  logic          bad_cmd,
    output logic [DW-1:0] ist_o,
    output logic [DW-1:0] cst_o
);

    typedef struct packed {
        logic [DW-1:0] ist;
        logic [DW-1:0] cst;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hot_rst) begin
            st_d.ist = DW'(IST_HOT);
            st_d.cst = '0;
        end else begin
            // software mask goes first
            if (ack_wr) begin
                st_d.ist = st_q.ist & ack_mask;
                if (!st_d.ist[B_DONE]) begin
                    st_d.cst = st_q.cst & ~DW'(ERR_BITS);
                end
            end
            // new events are merged on top
            if (done_evt.load) begin
                st_d.ist[B_DONE] = 1'b1;
                st_d.ist[B_LOAD] = 1'b1;
            end
            if (done_evt.prog) begin
                st_d.ist[B_DONE] = 1'b1;
                st_d.ist[B_PROG] = 1'b1;
            end
            if (done_evt.erase) begin
                st_d.ist[B_DONE]  = 1'b1;
                st_d.ist[B_ERASE] = 1'b1;
            end
            if (done_evt.reset) begin
                st_d.ist[B_DONE]  = 1'b1;
                st_d.ist[B_RESET] = 1'b1;
            end
            if (fail_evt.load) begin
                st_d.cst[E_CMD]  = 1'b1;
                st_d.cst[E_LOAD] = 1'b1;
            end
            if (fail_evt.prog) begin
                st_d.cst[E_CMD]  = 1'b1;
                st_d.cst[E_PROG] = 1'b1;
            end
            if (fail_evt.erase) begin
                st_d.cst[E_CMD]   = 1'b1;
                st_d.cst[E_ERASE] = 1'b1;
            end
            if (bad_cmd) begin
                st_d.cst[E_CMD]  = 1'b1;
                st_d.ist[B_DONE] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ist <= DW'(IST_COLD);
            st_q.cst <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ist_o = st_q.ist;
    assign cst_o = st_q.cst;

    AST_ERR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cst[E_LOAD] || st_q.cst[E_PROG] || st_q.cst[E_ERASE]) |-> st_q.cst[E_CMD]); // R4

    AST_LOAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt.load && !hot_rst) |=> (st_q.ist[B_DONE] && st_q.ist[B_LOAD])); // R6

    AST_ACK_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !ack_mask[B_DONE] && !hot_rst && !bad_cmd && (fail_evt == '0))
        |=> ((st_q.cst & DW'(ERR_BITS)) == '0)); // R5

    AST_HOT_IST: assert property (@(posedge clk) disable iff (!rst_n)
        hot_rst |=> (st_q.ist == DW'(IST_HOT))); // R2

endmodule

// File: rtl/fis_cmd_gate.sv
module fis_cmd_gate
    import fis_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hot_rst,
    input  logic          cmd_wr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          busy_flag,
    output logic          bad_cmd,
    output logic          issue_o,
    output logic [DW-1:0] code_o
);

    typedef struct packed {
        logic          issue;
        logic [DW-1:0] code;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     take;
    logic     known;

    always_comb begin
        take    = cmd_wr && !busy_flag && !hot_rst;
        known   = code_known(16'(cmd_wdata));
        bad_cmd = take && !known;
        st_d    = st_q;
        st_d.issue = take && known;
        if (hot_rst) begin
            st_d.code = '0;
        end else if (take) begin
            st_d.code = cmd_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_o = st_q.issue;
    assign code_o  = st_q.code;

    AST_ISSUE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |-> !$past(busy_flag)); // R7

    AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy_flag && !hot_rst) |=> ($stable(code_o) && !issue_o)); // R7

    AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> !issue_o); // R8

endmodule

// File: rtl/fis_pin_drive.sv
module fis_pin_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_rst,
    input  logic done_bit,
    input  logic pol_bit,
    input  logic rdy_bit,
    output logic irq_o,
    output logic rdy_o
);

    typedef struct packed {
        logic irq;
        logic rdy;
    } pin_st_t;

    pin_st_t st_d, st_q;

    always_comb begin
        st_d.irq = done_bit ^ ~pol_bit;
        st_d.rdy = hot_rst ? 1'b1 : rdy_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irq <= 1'b1;
            st_q.rdy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
    assign rdy_o = st_q.rdy;

endmodule

// File: rtl/flash_irq_status_unit.sv
module flash_irq_status_unit
    import fis_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hot_rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              evt_load,
    input  logic              evt_prog,
    input  logic              evt_erase,
    input  logic              evt_reset,
    input  logic              err_load,
    input  logic              err_prog,
    input  logic              err_erase,
    output logic              cmd_valid,
    output logic [DW-1:0]     cmd_code,
    output logic              irq_o,
    output logic              rdy_o
);

    localparam logic [DW-1:0] READ_MASK1 = ~DW'((1 << C_HIDE) - 1);

    typedef struct packed {
        logic [DW-1:0] cfg1;
        logic [DW-1:0] cfg2;
    } cfg_st_t;

    cfg_st_t   cfg_d, cfg_q;
    logic      sel_cmd, sel_cfg1, sel_cfg2, sel_cst, sel_ist;
    logic      bad_cmd;
    logic [DW-1:0] ist, cst;
    done_evt_t done_evt;
    fail_evt_t fail_evt;

    always_comb begin
        sel_cmd  = (reg_addr == ADDR_W'(RA_CMD));
        sel_cfg1 = (reg_addr == ADDR_W'(RA_CFG1));
        sel_cfg2 = (reg_addr == ADDR_W'(RA_CFG2));
        sel_cst  = (reg_addr == ADDR_W'(RA_CSTAT));
        sel_ist  = (reg_addr == ADDR_W'(RA_ISTAT));
        done_evt = '{load: evt_load, prog: evt_prog, erase: evt_erase, reset: evt_reset};
        fail_evt = '{load: err_load, prog: err_prog, erase: err_erase};
    end

    always_comb begin
        cfg_d = cfg_q;
        if (hot_rst) begin
            cfg_d.cfg1 = DW'(CFG1_DEF);
            cfg_d.cfg2 = DW'(CFG2_DEF);
        end else if (reg_wr) begin
            if (sel_cfg1) cfg_d.cfg1 = reg_wdata;
            if (sel_cfg2) cfg_d.cfg2 = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.cfg1 <= DW'(CFG1_DEF);
            cfg_q.cfg2 <= DW'(CFG2_DEF);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_cmd)  reg_rdata = cmd_code;
        if (sel_cfg1) reg_rdata = cfg_q.cfg1 & READ_MASK1;
        if (sel_cfg2) reg_rdata = cfg_q.cfg2;
        if (sel_cst)  reg_rdata = cst;
        if (sel_ist)  reg_rdata = ist;
    end

    fis_status_core #(.DW(DW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .hot_rst  (hot_rst),
        .ack_wr   (reg_wr && sel_ist),
        .ack_mask (reg_wdata),
        .done_evt (done_evt),
        .fail_evt (fail_evt),
        .bad_cmd  (bad_cmd),
        .ist_o    (ist),
        .cst_o    (cst)
    );

    fis_cmd_gate #(.DW(DW)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .hot_rst   (hot_rst),
        .cmd_wr    (reg_wr && sel_cmd),
        .cmd_wdata (reg_wdata),
        .busy_flag (ist[B_DONE]),
        .bad_cmd   (bad_cmd),
        .issue_o   (cmd_valid),
        .code_o    (cmd_code)
    );

    fis_pin_drive u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .hot_rst  (hot_rst),
        .done_bit (ist[B_DONE]),
        .pol_bit  (cfg_q.cfg1[C_POL]),
        .rdy_bit  (cfg_q.cfg1[C_RDY]),
        .irq_o    (irq_o),
        .rdy_o    (rdy_o)
    );

    AST_CFG1_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        sel_cfg1 |-> (reg_rdata[C_HIDE-1:0] == '0)); // R11

    AST_RDY_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        hot_rst |=> rdy_o); // R2

    AST_IRQ_ACTIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ist[B_DONE]) && $past(cfg_q.cfg1[C_POL])) |-> irq_o); // R9

endmodule

// File: tb/flash_irq_status_unit_bench.sv
module flash_irq_status_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hot_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        evt_load = 1'b0, evt_prog = 1'b0, evt_erase = 1'b0, evt_reset = 1'b0;
    logic        err_load = 1'b0, err_prog = 1'b0, err_erase = 1'b0;
    logic        cmd_valid;
    logic [15:0] cmd_code;
    logic        irq_o, rdy_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flash_irq_status_unit u_flash_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .hot_rst(hot_rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_load(evt_load), .evt_prog(evt_prog), .evt_erase(evt_erase), .evt_reset(evt_reset),
        .err_load(err_load), .err_prog(err_prog), .err_erase(err_erase),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .irq_o(irq_o), .rdy_o(rdy_o)
    );

    // scoreboard: 0 read data, 1 irq, 2 rdy, 3 cmd_valid, 4 cmd_code
    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    event      sb_kick;

    task automatic expect_sig(input int sel, input logic [15:0] exp, input string tag);
        exp_item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> sb_kick;
        #1;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a;
        #1;
        expect_sig(0, exp, tag);
    endtask

    initial begin
        forever begin
            @(sb_kick);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    0:       act = reg_rdata;
                    1:       act = {15'b0, irq_o};
                    2:       act = {15'b0, rdy_o};
                    3:       act = {15'b0, cmd_valid};
                    default: act = cmd_code;
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // bits: {err_erase, err_prog, err_load, evt_reset, evt_erase, evt_prog, evt_load}
    task automatic pulse(input logic [6:0] b);
        @(negedge clk);
        {err_erase, err_prog, err_load, evt_reset, evt_erase, evt_prog, evt_load} = b;
        @(negedge clk);
        {err_erase, err_prog, err_load, evt_reset, evt_erase, evt_prog, evt_load} = '0;
    endtask

    task automatic wr_pulse(input logic [2:0] a, input logic [15:0] d, input logic [6:0] b);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        {err_erase, err_prog, err_load, evt_reset, evt_erase, evt_prog, evt_load} = b;
        @(negedge clk);
        reg_wr = 1'b0;
        {err_erase, err_prog, err_load, evt_reset, evt_erase, evt_prog, evt_load} = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 cold reset state
        expect_rd(3'd4, 16'h8080, "R1 ist cold");
        expect_rd(3'd1, 16'h40C0, "R1 cfg1");
        expect_rd(3'd2, 16'h0000, "R1 cfg2");
        expect_rd(3'd3, 16'h0000, "R1 cst");
        expect_rd(3'd0, 16'h0000, "R1 cmd");
        expect_sig(2, 16'h1, "R1 rdy");
        expect_sig(1, 16'h1, "R1 irq");

        // R7 command blocked while done flag set
        wr(3'd0, 16'h0080);
        expect_sig(3, 16'h0, "R7 blocked no strobe");
        expect_rd(3'd0, 16'h0000, "R7 blocked cmd kept");

        // R5 acknowledge, R9 pin follows one cycle later
        wr(3'd4, 16'h0000);
        expect_rd(3'd4, 16'h0000, "R5 ack clears ist");
        tick();
        expect_sig(1, 16'h0, "R9 irq idle active-high");

        // R12 accepted command
        wr(3'd0, 16'h0080);
        expect_sig(3, 16'h1, "R12 strobe");
        expect_sig(4, 16'h0080, "R12 code");
        expect_rd(3'd0, 16'h0080, "R12 readback");
        tick();
        expect_sig(3, 16'h0, "R12 strobe single cycle");

        // R3 program done, R4 program error
        pulse(7'b0000010);
        expect_rd(3'd4, 16'h8040, "R3 prog done");
        tick();
        expect_sig(1, 16'h1, "R9 irq asserted");
        pulse(7'b0100000);
        expect_rd(3'd3, 16'h1400, "R4 prog err pair");

        // R5 partial mask keeps errors, full clear wipes them
        wr(3'd4, 16'h8000);
        expect_rd(3'd4, 16'h8000, "R5 partial mask");
        expect_rd(3'd3, 16'h1400, "R5 errors kept");
        wr(3'd4, 16'h7FFF);
        expect_rd(3'd4, 16'h0000, "R5 done cleared");
        expect_rd(3'd3, 16'h0000, "R5 errors wiped");

        // R8 unknown command
        wr(3'd0, 16'h0042);
        expect_sig(3, 16'h0, "R8 no strobe");
        expect_rd(3'd3, 16'h0400, "R8 cmd error");
        expect_rd(3'd4, 16'h8000, "R8 done set");

        // R6 ack and events in the same cycle
        wr_pulse(3'd4, 16'h0000, 7'b0010001);
        expect_rd(3'd4, 16'h8080, "R6 load kept");
        expect_rd(3'd3, 16'h2400, "R6 load err kept");

        // R4 erase error
        wr(3'd4, 16'h0000);
        pulse(7'b1000000);
        expect_rd(3'd3, 16'h0C00, "R4 erase err pair");
        wr(3'd4, 16'h0000);
        expect_rd(3'd3, 16'h0000, "R5 clear with done low");

        // R9 polarity, R10 ready, R11 read mask
        wr(3'd1, 16'h0000);
        expect_rd(3'd1, 16'h0000, "R11 cfg1 zero");
        tick();
        expect_sig(1, 16'h1, "R9 active-low idle");
        expect_sig(2, 16'h0, "R10 rdy low");
        wr(3'd1, 16'hFFFF);
        expect_rd(3'd1, 16'hFFE0, "R11 cfg1 masked");
        tick();
        expect_sig(1, 16'h0, "R9 active-high idle");
        expect_sig(2, 16'h1, "R10 rdy high");
        wr(3'd2, 16'h1234);
        expect_rd(3'd2, 16'h1234, "R11 cfg2 full");

        // R3 erase done, then prepare hot reset
        pulse(7'b0000100);
        expect_rd(3'd4, 16'h8020, "R3 erase done");
        pulse(7'b0010000);
        wr(3'd1, 16'h0000);
        tick();
        expect_sig(2, 16'h0, "R10 rdy low again");
        expect_sig(1, 16'h0, "R9 active-low asserted");

        // R2 hot reset
        @(negedge clk);
        hot_rst = 1'b1;
        @(negedge clk);
        hot_rst = 1'b0;
        expect_rd(3'd4, 16'h8010, "R2 ist hot");
        expect_rd(3'd1, 16'h40C0, "R2 cfg1");
        expect_rd(3'd2, 16'h0000, "R2 cfg2");
        expect_rd(3'd3, 16'h0000, "R2 cst");
        expect_sig(2, 16'h1, "R2 rdy raised");
        tick();
        expect_sig(1, 16'h1, "R9 irq after hot");

        // R7 blocked after hot reset, then accepted
        wr(3'd0, 16'h0094);
        expect_sig(3, 16'h0, "R7 blocked after hot");
        expect_rd(3'd0, 16'h0000, "R7 cmd cleared");
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0094);
        expect_sig(3, 16'h1, "R12 erase strobe");
        expect_sig(4, 16'h0094, "R12 erase code");

        // R3 reset done
        pulse(7'b0001000);
        expect_rd(3'd4, 16'h8010, "R3 reset done");

        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule